// File: doc/BRIEF.md
# Blitter Window Size Front End and Scan Sequencer

This block is the front end of a 2D block-transfer engine. Software programs the size of the rectangular window through a 16-bit register write port. A write to the correct register also launches the transfer. While the transfer runs, the block walks a word counter across each line and a line counter down the window. It moves one word for each advance strobe it receives from the datapath. It reports the current position and flags the last word of each line and the last word of the whole window.

There are two ways to program the size. The first is a compact legacy register. It packs both dimensions into one word, and writing it starts the blit at once. The second is an extended pair with a wider range. The height is written first and is only held in a staging register. The later width write uses that staged height and starts the blit. In every field, a value of zero stands for the largest size that field can express. The advance strobe is a plain control pulse and not a valid/ready stream. The datapath pulses it once for each word it has finished, so the sequencer never applies back-pressure. The block also drives a constant capability flag, which tells software that the extended pair exists.

Top module: `blit_size_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `eol` and `done` are 0, and `word_col` and `line_idx` are 0.
- R2: When idle, a write with `cfg_sel`=0 (packed) starts a blit. The height in lines comes from `cfg_wdata[15:6]` and the width in 16-pixel words comes from `cfg_wdata[5:0]`. `busy` is 1 from the following cycle, with both counters at 0.
- R3: In the packed format, a height field of 0 means 1024 lines and a width field of 0 means 64 words.
- R4: A write with `cfg_sel`=1 stores the height from `cfg_wdata[14:0]` and starts nothing. The stored height is kept until the next such write, so several blits can use it. It resets to 0.
- R5: When idle, a write with `cfg_sel`=2 starts a blit with the width in words from `cfg_wdata[10:0]` and the stored height.
- R6: In the extended format, a height of 0 means 32768 lines and a width of 0 means 2048 words.
- R7: While `busy` is 1, each cycle with `step`=1 advances `word_col` by one. In the same cycle as the strobe on the last word of a line, `eol` is 1, and on the next cycle `word_col` is 0 and `line_idx` has advanced by one.
- R8: `done` is 1 only together with `eol` on the last word of the last line. On the next cycle `busy` is 0 and both counters are 0.
- R9: While `busy` is 1, writes with `cfg_sel`=0 or 2 are ignored, and the running blit keeps its dimensions.
- R10: While idle, `step` has no effect. The counters stay at 0 and `eol` and `done` stay 0.
- R11: `big_blit_cap` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 packed, 1 height, 2 width and start |
| cfg_wdata | input | 16 | Register write data |
| step | input | 1 | Datapath advance strobe, one word per pulse |
| busy | output | 1 | Blit in progress |
| word_col | output | 11 | Current word within the line |
| line_idx | output | 15 | Current line |
| eol | output | 1 | The strobe in this cycle completes a line |
| done | output | 1 | The strobe in this cycle completes the blit |
| big_blit_cap | output | 1 | The extended size pair is present |

## Verification
The hardest cases are the zero encodings at full scale, because they need a very long run before the final wrap shows up. A zero extended height means 32768 lines, and a zero packed height means 1024 lines. The bench reaches these wraps by pairing each maximum height with a one-word width, and the zero widths with a one-line height. It then strobes `step` on every cycle and checks every position against an arithmetic model. Writes during a blit that are meant to be ignored are tested by issuing them between the start and the first strobe. The scan that follows must still have the original dimensions.

// File: rtl/blit_size_pkg.sv
package blit_size_pkg;
  typedef enum logic [1:0] {
    SEL_PACKED = 2'd0,
    SEL_VERT   = 2'd1,
    SEL_HORZ   = 2'd2,
    SEL_NONE   = 2'd3
  } size_sel_e;
endpackage

// File: rtl/blit_wrap_counter.sv
module blit_wrap_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         at_limit
);
  assign at_limit = (count == limit);

  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (inc)
      count <= at_limit ? '0 : count + W'(1);
  end
endmodule

// File: rtl/blit_size_regs.sv
module blit_size_regs
  import blit_size_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LEG_W_BITS = 6,
  parameter int LEG_H_BITS = 10,
  parameter int EXT_W_BITS = 11,
  parameter int EXT_H_BITS = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_sel,
  input  logic [DATA_W-1:0]     cfg_wdata,
  input  logic                  busy,
  output logic                  start,
  output logic [EXT_W_BITS-1:0] start_last_w,
  output logic [EXT_H_BITS-1:0] start_last_h
);
  localparam int LEG_H_LSB = LEG_W_BITS;

  logic [EXT_H_BITS-1:0] staged_h;
  logic [LEG_W_BITS-1:0] leg_last_w;
  logic [LEG_H_BITS-1:0] leg_last_h;
  logic [EXT_W_BITS-1:0] ext_last_w;
  logic [EXT_H_BITS-1:0] ext_last_h;
  size_sel_e             sel;

  assign sel = size_sel_e'(cfg_sel);

  // Zero-means-max: subtracting one modulo 2^n turns a field into its last index
  always_comb begin
    leg_last_w = cfg_wdata[LEG_W_BITS-1:0] - LEG_W_BITS'(1);
    leg_last_h = cfg_wdata[LEG_H_LSB +: LEG_H_BITS] - LEG_H_BITS'(1);
    ext_last_w = cfg_wdata[EXT_W_BITS-1:0] - EXT_W_BITS'(1);
    ext_last_h = staged_h - EXT_H_BITS'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      staged_h <= '0;
    else if (cfg_wr && sel == SEL_VERT)
      staged_h <= cfg_wdata[EXT_H_BITS-1:0];
  end

  always_comb begin
    start        = 1'b0;
    start_last_w = '0;
    start_last_h = '0;
    if (cfg_wr && !busy) begin
      unique case (sel)
        SEL_PACKED: begin
          start        = 1'b1;
          start_last_w = EXT_W_BITS'(leg_last_w);
          start_last_h = EXT_H_BITS'(leg_last_h);
        end
        SEL_HORZ: begin
          start        = 1'b1;
          start_last_w = ext_last_w;
          start_last_h = ext_last_h;
        end
        default: ;
      endcase
    end
  end

  assert_vert_no_start_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && sel == SEL_VERT) |-> !start);
  assert_busy_blocks_start_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/blit_scan_seq.sv
module blit_scan_seq #(
  parameter int COL_W  = 11,
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [COL_W-1:0]  start_last_w,
  input  logic [LINE_W-1:0] start_last_h,
  input  logic              step,
  output logic              busy,
  output logic [COL_W-1:0]  word_col,
  output logic [LINE_W-1:0] line_idx,
  output logic              eol,
  output logic              done
);
  logic [COL_W-1:0]  last_w;
  logic [LINE_W-1:0] last_h;
  logic              col_at, line_at, adv;

  assign adv  = busy && step;
  assign eol  = adv && col_at;
  assign done = eol && line_at;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      last_w <= '0;
      last_h <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      last_w <= start_last_w;
      last_h <= start_last_h;
    end else if (done) begin
      busy   <= 1'b0;
    end
  end

  blit_wrap_counter #(.W(COL_W)) u_col (
    .clk(clk), .rst(rst), .clear(start), .inc(adv),
    .limit(last_w), .count(word_col), .at_limit(col_at)
  );

  blit_wrap_counter #(.W(LINE_W)) u_line (
    .clk(clk), .rst(rst), .clear(start), .inc(eol),
    .limit(last_h), .count(line_idx), .at_limit(line_at)
  );

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && word_col == '0 && line_idx == '0));
  assert_col_in_window_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (word_col <= last_w && line_idx <= last_h));
  assert_eol_wraps_R7: assert property (@(posedge clk) disable iff (rst)
    (eol && !done) |=> (word_col == '0 && line_idx == $past(line_idx) + LINE_W'(1)));
  assert_done_needs_eol_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> eol);
  assert_done_idles_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && word_col == '0 && line_idx == '0));
  assert_idle_still_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (word_col == '0 && line_idx == '0 && !eol));
endmodule

// File: rtl/blit_size_seq.sv
module blit_size_seq #(
  parameter int DATA_W     = 16,
  parameter int LEG_W_BITS = 6,
  parameter int LEG_H_BITS = 10,
  parameter int EXT_W_BITS = 11,
  parameter int EXT_H_BITS = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_sel,
  input  logic [DATA_W-1:0]     cfg_wdata,
  input  logic                  step,
  output logic                  busy,
  output logic [EXT_W_BITS-1:0] word_col,
  output logic [EXT_H_BITS-1:0] line_idx,
  output logic                  eol,
  output logic                  done,
  output logic                  big_blit_cap
);
  logic                  start;
  logic [EXT_W_BITS-1:0] start_last_w;
  logic [EXT_H_BITS-1:0] start_last_h;

  assign big_blit_cap = 1'b1;

  blit_size_regs #(
    .DATA_W(DATA_W), .LEG_W_BITS(LEG_W_BITS), .LEG_H_BITS(LEG_H_BITS),
    .EXT_W_BITS(EXT_W_BITS), .EXT_H_BITS(EXT_H_BITS)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .start(start),
    .start_last_w(start_last_w), .start_last_h(start_last_h)
  );

  blit_scan_seq #(.COL_W(EXT_W_BITS), .LINE_W(EXT_H_BITS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_last_w(start_last_w),
    .start_last_h(start_last_h), .step(step), .busy(busy),
    .word_col(word_col), .line_idx(line_idx), .eol(eol), .done(done)
  );

  assert_cap_flag_R11: assert property (@(posedge clk) disable iff (rst)
    big_blit_cap);
endmodule

// File: tb/blit_size_seq_bench.sv
module blit_size_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        step;
  logic        busy, eol, done, big_blit_cap;
  logic [10:0] word_col;
  logic [14:0] line_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  blit_size_seq u_blit_size_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .step(step), .busy(busy), .word_col(word_col),
    .line_idx(line_idx), .eol(eol), .done(done), .big_blit_cap(big_blit_cap)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Strobe every cycle and compare position and flags with the model; one check per blit
  task automatic run_scan(input int w, input int h, input string req);
    int bad = 0;
    int first_bad = -1;
    for (int l = 0; l < h; l++) begin
      for (int c = 0; c < w; c++) begin
        bit last_c = (c == w - 1);
        bit last_l = (l == h - 1);
        step = 1'b1;
        #1;
        if (!busy || word_col != c[10:0] || line_idx != l[14:0] ||
            eol != last_c || done != (last_c && last_l)) begin
          if (first_bad < 0) first_bad = l * w + c;
          bad++;
        end
        @(negedge clk);
      end
    end
    step = 1'b0;
    check(bad == 0, {req, " scan"}, first_bad, -1);
    #1;
    check(!busy && word_col == 0 && line_idx == 0, {req, " idle after done R8"},
          int'(busy), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0; step = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!busy && !eol && !done && word_col == 0 && line_idx == 0,
          "R1 reset state", int'(busy), 0);
    check(big_blit_cap == 1'b1, "R11 capability flag", int'(big_blit_cap), 1);

    // R10: strobes while idle do nothing
    begin
      int bad = 0;
      for (int i = 0; i < 5; i++) begin
        step = 1'b1; #1;
        if (busy || eol || done || word_col != 0 || line_idx != 0) bad++;
        @(negedge clk);
      end
      step = 1'b0;
      check(bad == 0, "R10 idle step ignored", bad, 0);
    end

    // R2 / R7 / R8: packed sweep over small windows
    for (int h = 1; h <= 4; h++)
      for (int w = 1; w <= 4; w++) begin
        wr(2'd0, 16'((h << 6) | w));
        run_scan(w, h, "R2 R7 packed");
      end

    // R3: zero fields in packed form
    wr(2'd0, 16'((1 << 6) | 0));
    run_scan(64, 1, "R3 packed width zero");
    wr(2'd0, 16'((0 << 6) | 1));
    run_scan(1, 1024, "R3 packed height zero");

    // R4: height write only stages
    wr(2'd1, 16'd3);
    check(!busy, "R4 height write does not start", int'(busy), 0);
    repeat (4) @(negedge clk);
    #1;
    check(!busy, "R4 still idle", int'(busy), 0);

    // R5 and R4 persistence
    wr(2'd2, 16'd2);
    run_scan(2, 3, "R5 extended");
    wr(2'd2, 16'd5);
    run_scan(5, 3, "R4 staged height reused");
    for (int h = 1; h <= 7; h += 3)
      for (int w = 1; w <= 5; w += 2) begin
        wr(2'd1, 16'(h));
        wr(2'd2, 16'(w));
        run_scan(w, h, "R5 extended sweep");
      end

    // R9: start writes while busy are ignored
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'((1 << 6) | 1));
    wr(2'd2, 16'd7);
    run_scan(3, 2, "R9 busy writes ignored");

    // R6: zero fields in extended form
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd0);
    run_scan(2048, 1, "R6 extended width zero");
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd1);
    run_scan(1, 32768, "R6 extended height zero");

    // R1: reset in the middle of a blit
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd4);
    step = 1'b1;
    repeat (3) @(negedge clk);
    step = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    check(!busy && word_col == 0 && line_idx == 0, "R1 reset mid blit",
          int'(busy), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule